// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block keeps the seven time-of-day and calendar registers of a PC-style real-time clock and advances them once per second. A prescaler counts timebase ticks (32,768 per second by default). A small state machine raises an update-in-progress status a fixed number of ticks before each second boundary. At the boundary it steps all seven registers in one clock, then emits a single-cycle update-ended pulse for an interrupt flag register downstream.

Registers keep whatever encoding software writes into them. On every step the stepper decodes them, increments them and re-encodes them using the current data-mode bit (BCD or binary) and hour-format bit (24-hour, or 12-hour with a PM flag in bit 7). A hold bit stops updates so that software can load the clock through the write port. A three-bit divider field either runs the prescaler, freezes it, or holds it in reset.

The sequencer states are `ST_IDLE`, `ST_LEAD` and `ST_STEP`:

- `ST_IDLE` moves to `ST_LEAD` on the lead-start tick when the hold bit is clear.
- `ST_LEAD` moves back to `ST_IDLE` if the hold bit is set or the divider leaves run mode. Otherwise it moves to `ST_STEP` on the second-boundary tick.
- `ST_STEP` always returns to `ST_IDLE`. It applies the step on that edge.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset the registers read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0. The status output `uip` and the pulse output `upd_done` are 0.
- R2: `uip` is high from the lead-start point until the new values appear, and falls on that same edge. With a tick on every clock this is LEAD_TICKS+1 clocks. Registers never change without a write unless `uip` was high in the previous cycle.
- R3: `upd_done` is high for exactly one clock, in the first cycle the stepped values are visible.
- R4: With `bin_mode`=1 the seconds 59 to 0 and minutes 59 to 0 rollovers each carry into the next field.
- R5: With `bin_mode`=0 every field is two BCD digits (tens in bits 7:4). The step carries 0x09 to 0x10, and 0x59 rolls to 0x00.
- R6: With `h24`=1 hours run 0 to 23, and 23 to 0 advances the day. The weekday runs 1 to 7, and 7 wraps to 1.
- R7: With `h24`=0 hours run 1 to 12 in bits 6:0, with bit 7 set for PM. The transitions are:
    - 11 AM steps to 12 PM (0x92 in BCD).
    - 12 PM steps to 1 PM (0x81).
    - 11 PM steps to 12 AM and advances the day.
- R8: Month lengths are applied as follows:
    - Months 4, 6, 9 and 11 have 30 days.
    - Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise.
    - All other months have 31 days.
    - Month 12 rolls to 1 and advances the year.
    - Year 99 rolls to 0.
- R9: While `set_hold`=1 the registers are not stepped. `uip` stays 0 from the second cycle of the hold onward, and no `upd_done` is produced.
- R10: A write with `wr_sel` 0..6 loads seconds, minutes, hours, weekday, day, month or year, and is visible after the next clock edge. Clearing `set_hold` resumes stepping from the written values.
- R11: `div_sel` values 3'b110 and 3'b111 hold the prescaler in reset, and `uip` is 0 in the next cycle. `div_sel`=3'b010 runs the prescaler; other values freeze it. After the prescaler leaves reset, the first step happens after TICKS_PER_SEC ticks. With a tick on every clock, the new values are seen on the TICKS_PER_SEC+1-th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock timebase tick |
| div_sel | input | 3 | Divider control: 010 run, 11x reset, others freeze |
| set_hold | input | 1 | Inhibits updates while high |
| bin_mode | input | 1 | 1 binary data, 0 BCD data |
| h24 | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM in bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Field select 0..6 (sec, min, hour, weekday, day, month, year) |
| wr_data | input | 8 | Write data |
| seconds | output | 8 | Seconds register |
| minutes | output | 8 | Minutes register |
| hours | output | 8 | Hours register |
| weekday | output | 8 | Day-of-week register |
| mday | output | 8 | Day-of-month register |
| month | output | 8 | Month register |
| year | output | 8 | Two-digit year register |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | Update-ended event pulse |

## Verification
The stepper is driven from start times chosen to sit on each carry boundary:

- A full carry from 23:59:59 on December 31, year 99, in binary 24-hour mode exercises every field at once.
- BCD single-digit and tens carries separate decimal from binary wrapping.
- The three 12-hour transitions around noon and midnight distinguish toggling the PM flag from advancing the day.
- Thirty-day months, leap and non-leap February, and a BCD January 31 separate the month-length rules.

Holding, writing under hold and resuming check that the freeze affects only stepping. Releasing the divider from reset fixes the one-second distance to the first update.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STEP
    } seq_state_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    localparam logic [2:0] FLD_SEC  = 3'd0;
    localparam logic [2:0] FLD_MIN  = 3'd1;
    localparam logic [2:0] FLD_HOUR = 3'd2;
    localparam logic [2:0] FLD_WDAY = 3'd3;
    localparam logic [2:0] FLD_MDAY = 3'd4;
    localparam logic [2:0] FLD_MON  = 3'd5;
    localparam logic [2:0] FLD_YEAR = 3'd6;

    localparam logic [2:0] DIV_RUN = 3'b010;

    // Decode a stored byte to a binary value in the current data mode.
    function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
        logic [6:0] r;
        if (bin) r = v[6:0];
        else     r = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
        return r;
    endfunction

    // Encode a binary value back to a stored byte in the current data mode.
    function automatic logic [7:0] to_enc(input logic [6:0] b, input logic bin);
        logic [6:0] q;
        logic [6:0] r;
        q = b / 7'd10;
        r = b % 7'd10;
        if (bin) return {1'b0, b};
        return {q[3:0], r[3:0]};
    endfunction

    function automatic logic [6:0] days_in(input logic [6:0] mon, input logic [6:0] yr);
        logic [6:0] d;
        case (mon)
            7'd2:                      d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   d = 7'd30;
            default:                   d = 7'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div_sel,
    output logic       running,
    output logic       lead_start,
    output logic       sec_edge
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST_CNT = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] LEAD_CNT = CW'(TICKS_PER_SEC - 1 - LEAD_TICKS);

    logic [CW-1:0] cnt;
    logic          div_rst;

    assign div_rst    = (div_sel[2:1] == 2'b11);
    assign running    = (div_sel == DIV_RUN);
    assign lead_start = running && tick && (cnt == LEAD_CNT);
    assign sec_edge   = running && tick && (cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n || div_rst) begin
            cnt <= '0;
        end else if (running && tick) begin
            cnt <= (cnt == LAST_CNT) ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_seq_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin_mode,
    input  logic      h24,
    output rtc_time_t nxt
);
    logic [6:0] s, m, hb, w, d, mo, yr, dim;
    logic [6:0] ns, nm, nh, nw, nd, nmo, nyr;
    logic       pm, npm;
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] h_enc;

    always_comb begin
        s   = to_bin(cur.sec,  bin_mode);
        m   = to_bin(cur.min,  bin_mode);
        hb  = to_bin({1'b0, cur.hour[6:0]}, bin_mode);
        pm  = cur.hour[7];
        w   = to_bin(cur.wday, bin_mode);
        d   = to_bin(cur.mday, bin_mode);
        mo  = to_bin(cur.mon,  bin_mode);
        yr  = to_bin(cur.year, bin_mode);
        dim = days_in(mo, yr);

        c_min  = (s >= 7'd59);
        ns     = c_min ? 7'd0 : s + 7'd1;
        c_hour = c_min && (m >= 7'd59);
        nm     = c_min ? (c_hour ? 7'd0 : m + 7'd1) : m;

        nh    = hb;
        npm   = pm;
        c_day = 1'b0;
        if (c_hour) begin
            if (h24) begin
                if (hb >= 7'd23) begin
                    nh    = 7'd0;
                    c_day = 1'b1;
                end else begin
                    nh = hb + 7'd1;
                end
            end else begin
                if (hb >= 7'd12) begin
                    nh = 7'd1;
                end else if (hb == 7'd11) begin
                    nh    = 7'd12;
                    npm   = ~pm;
                    c_day = pm;
                end else begin
                    nh = hb + 7'd1;
                end
            end
        end

        nw     = c_day ? ((w >= 7'd7) ? 7'd1 : w + 7'd1) : w;
        c_mon  = c_day && (d >= dim);
        nd     = c_day ? (c_mon ? 7'd1 : d + 7'd1) : d;
        c_year = c_mon && (mo >= 7'd12);
        nmo    = c_mon ? (c_year ? 7'd1 : mo + 7'd1) : mo;
        nyr    = c_year ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;

        h_enc = to_enc(nh, bin_mode);

        nxt.sec  = to_enc(ns,  bin_mode);
        nxt.min  = to_enc(nm,  bin_mode);
        nxt.hour = h24 ? h_enc : {npm, h_enc[6:0]};
        nxt.wday = to_enc(nw,  bin_mode);
        nxt.mday = to_enc(nd,  bin_mode);
        nxt.mon  = to_enc(nmo, bin_mode);
        nxt.year = to_enc(nyr, bin_mode);
    end

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div_sel,
    input  logic       set_hold,
    input  logic       bin_mode,
    input  logic       h24,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] seconds,
    output logic [7:0] minutes,
    output logic [7:0] hours,
    output logic [7:0] weekday,
    output logic [7:0] mday,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic       uip,
    output logic       upd_done
);
    localparam rtc_time_t RESET_TIME = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                         wday: 8'd1, mday: 8'd1, mon: 8'd1,
                                         year: 8'd0};

    seq_state_t state, state_nx;
    rtc_time_t  cur, stepped, cur_nx;
    logic       running, lead_start, sec_edge;
    logic       done_q;

    rtc_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .LEAD_TICKS    (LEAD_TICKS)
    ) i_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .div_sel    (div_sel),
        .running    (running),
        .lead_start (lead_start),
        .sec_edge   (sec_edge)
    );

    rtc_cal_step i_step (
        .cur      (cur),
        .bin_mode (bin_mode),
        .h24      (h24),
        .nxt      (stepped)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (lead_start && !set_hold) state_nx = ST_LEAD;
            ST_LEAD: begin
                if (set_hold || !running) state_nx = ST_IDLE;
                else if (sec_edge)        state_nx = ST_STEP;
            end
            ST_STEP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Register file next value: step first, host write overrides its field
    always_comb begin
        cur_nx = (state == ST_STEP) ? stepped : cur;
        if (wr_en) begin
            case (wr_sel)
                FLD_SEC:  cur_nx.sec  = wr_data;
                FLD_MIN:  cur_nx.min  = wr_data;
                FLD_HOUR: cur_nx.hour = wr_data;
                FLD_WDAY: cur_nx.wday = wr_data;
                FLD_MDAY: cur_nx.mday = wr_data;
                FLD_MON:  cur_nx.mon  = wr_data;
                FLD_YEAR: cur_nx.year = wr_data;
                default:  ;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= RESET_TIME;
            done_q <= 1'b0;
        end else begin
            cur    <= cur_nx;
            done_q <= (state == ST_STEP);
        end
    end

    assign uip      = (state != ST_IDLE);
    assign upd_done = done_q;
    assign seconds  = cur.sec;
    assign minutes  = cur.min;
    assign hours    = cur.hour;
    assign weekday  = cur.wday;
    assign mday     = cur.mday;
    assign month    = cur.mon;
    assign year     = cur.year;

endmodule

// File: rtl/rtc_update_seq_chk.sv
module rtc_update_seq_chk
    import rtc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] div_sel,
    input logic       set_hold,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] seconds,
    input logic       uip,
    input logic       upd_done
);
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R2
    change_needs_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$stable(seconds)) |-> $past(uip));

    // R3
    done_ends_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $fell(uip));

    // R9
    hold_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && $past(set_hold)) |-> !uip);

    // R11
    div_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel[2:1] == 2'b11) |=> !uip);

    // R10
    sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_SEC) |=> (seconds == $past(wr_data)));

endmodule

bind rtc_update_seq rtc_update_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .set_hold (set_hold),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .seconds  (seconds),
    .uip      (uip),
    .upd_done (upd_done)
);

// File: tb/test_rtc_update_seq.sv
module test_rtc_update_seq;
    import rtc_seq_pkg::*;

    localparam int TPS  = 16;
    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [2:0] div_sel = 3'b110;
    logic       set_hold = 1'b1;
    logic       bin_mode = 1'b1;
    logic       h24 = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] seconds, minutes, hours, weekday, mday, month, year;
    logic       uip, upd_done;

    int    checks = 0;
    int    failures = 0;
    int    uip_run = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";
    rtc_time_t exp_q[$];

    always #10 clk = ~clk;

    rtc_update_seq #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD)) i_rtc_update_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_sel(div_sel),
        .set_hold(set_hold), .bin_mode(bin_mode), .h24(h24),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seconds(seconds), .minutes(minutes), .hours(hours),
        .weekday(weekday), .mday(mday), .month(month), .year(year),
        .uip(uip), .upd_done(upd_done)
    );

    function automatic rtc_time_t mk(input logic [7:0] s, m, h, w, d, mo, y);
        rtc_time_t t;
        t = '{sec: s, min: m, hour: h, wday: w, mday: d, mon: mo, year: y};
        return t;
    endfunction

    function automatic rtc_time_t now();
        return mk(seconds, minutes, hours, weekday, mday, month, year);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (upd_done) begin
                // R2: uip high LEAD+1 clocks before the new values
                chk(uip_run == LEAD + 1, "R2", "uip lead clocks", 64'(uip_run), 64'(LEAD + 1));
                uip_run = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected update", 64'(now()), 64'd0);
                end else begin
                    rtc_time_t e;
                    e = exp_q.pop_front();
                    chk(now() == e, cur_tag, "stepped time", 64'(now()), 64'(e));
                end
            end else if (uip) begin
                uip_run++;
            end else begin
                uip_run = 0;
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input rtc_time_t t);
        wr(FLD_SEC, t.sec);   wr(FLD_MIN, t.min);   wr(FLD_HOUR, t.hour);
        wr(FLD_WDAY, t.wday); wr(FLD_MDAY, t.mday); wr(FLD_MON, t.mon);
        wr(FLD_YEAR, t.year);
    endtask

    // Driver: load start time under hold and divider reset, push expected, release.
    task automatic run_case(input string tag, input logic bm, input logic h,
                            input rtc_time_t start, input rtc_time_t exp);
        int n;
        @(negedge clk);
        div_sel = 3'b110; set_hold = 1'b1; bin_mode = bm; h24 = h;
        load(start);
        cur_tag = tag;
        exp_q.push_back(exp);
        set_hold = 1'b0;
        div_sel = 3'b010;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_done && n < 4 * TPS);
        // R11: first update one second after leaving divider reset
        chk(n == TPS + 1, "R11", "edges to first update", 64'(n), 64'(TPS + 1));
        @(negedge clk);
        // R3: single-cycle pulse
        chk(upd_done == 1'b0, "R3", "pulse width", 64'(upd_done), 64'd0);
        div_sel = 3'b110;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(now() == mk(0, 0, 0, 1, 1, 1, 0), "R1", "reset time", 64'(now()),
            64'(mk(0, 0, 0, 1, 1, 1, 0)));
        chk(!uip && !upd_done, "R1", "reset flags", {62'd0, uip, upd_done}, 64'd0);

        // R4 R6 R8: full carry in binary 24-hour mode
        run_case("R4", 1, 1, mk(59, 59, 23, 7, 31, 12, 99), mk(0, 0, 0, 1, 1, 1, 0));
        // R5: BCD digit carry and tens rollover
        run_case("R5", 0, 1, mk(8'h09, 8'h12, 8'h05, 2, 8'h14, 8'h06, 8'h21),
                             mk(8'h10, 8'h12, 8'h05, 2, 8'h14, 8'h06, 8'h21));
        run_case("R5", 0, 1, mk(8'h59, 8'h59, 8'h09, 2, 8'h14, 8'h06, 8'h21),
                             mk(8'h00, 8'h00, 8'h10, 2, 8'h14, 8'h06, 8'h21));
        // R7: 12-hour transitions (BCD)
        run_case("R7", 0, 0, mk(8'h59, 8'h59, 8'h11, 3, 8'h05, 8'h07, 8'h22),
                             mk(8'h00, 8'h00, 8'h92, 3, 8'h05, 8'h07, 8'h22));
        run_case("R7", 0, 0, mk(8'h59, 8'h59, 8'h92, 3, 8'h05, 8'h07, 8'h22),
                             mk(8'h00, 8'h00, 8'h81, 3, 8'h05, 8'h07, 8'h22));
        run_case("R7", 0, 0, mk(8'h59, 8'h59, 8'h91, 3, 8'h05, 8'h07, 8'h22),
                             mk(8'h00, 8'h00, 8'h12, 4, 8'h06, 8'h07, 8'h22));
        // R7 R6: binary 12-hour, 11 PM on year end
        run_case("R7", 1, 0, mk(59, 59, 8'h8B, 7, 31, 12, 99), mk(0, 0, 8'h0C, 1, 1, 1, 0));
        // R8: month lengths
        run_case("R8", 1, 1, mk(59, 59, 23, 2, 30, 4, 23), mk(0, 0, 0, 3, 1, 5, 23));
        run_case("R8", 1, 1, mk(59, 59, 23, 2, 28, 2, 24), mk(0, 0, 0, 3, 29, 2, 24));
        run_case("R8", 1, 1, mk(59, 59, 23, 2, 29, 2, 24), mk(0, 0, 0, 3, 1, 3, 24));
        run_case("R8", 1, 1, mk(59, 59, 23, 2, 28, 2, 23), mk(0, 0, 0, 3, 1, 3, 23));
        run_case("R8", 0, 1, mk(8'h59, 8'h59, 8'h23, 5, 8'h31, 8'h01, 8'h09),
                             mk(8'h00, 8'h00, 8'h00, 6, 8'h01, 8'h02, 8'h09));

        // R9: hold freezes stepping
        run_case("R6", 1, 1, mk(10, 20, 5, 4, 9, 9, 30), mk(11, 20, 5, 4, 9, 9, 30));
        @(negedge clk);
        set_hold = 1'b1;
        div_sel = 3'b010;
        @(negedge clk);
        begin
            bit saw_uip;
            saw_uip = 1'b0;
            for (int i = 0; i < 3 * TPS; i++) begin
                @(negedge clk);
                if (uip || upd_done) saw_uip = 1'b1;
            end
            chk(!saw_uip, "R9", "uip or pulse under hold", 64'(saw_uip), 64'd0);
        end
        chk(now() == mk(11, 20, 5, 4, 9, 9, 30), "R9", "time frozen", 64'(now()),
            64'(mk(11, 20, 5, 4, 9, 9, 30)));

        // R10: write under hold is immediate, resume from written value
        wr(FLD_SEC, 8'd40);
        chk(seconds == 8'd40, "R10", "seconds after write", 64'(seconds), 64'd40);
        cur_tag = "R10";
        exp_q.push_back(mk(41, 20, 5, 4, 9, 9, 30));
        set_hold = 1'b0;
        begin
            int n;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!upd_done && n < 4 * TPS);
            chk(n < 4 * TPS, "R10", "resumed update seen", 64'(n), 64'(2 * TPS));
        end
        div_sel = 3'b110;
        repeat (2 * TPS) @(negedge clk);
        // R3: every expected update was produced
        chk(exp_q.size() == 0, "R3", "pending expected updates", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule